// File: doc/BRIEF.md
# SDRAM Timing Configuration Sequencer

This block holds the run-time timing setting of an SDRAM controller and turns it into the control signals that the datapath uses. A host writes one byte. Only the low six bits count, so software can sweep 64 settings. The setting picks four things: the SDRAM clock phase, the edge on which read data is captured, whether one extra cycle of read latency is added, and whether the clock phase is flipped while write data is driven. The SDRAM clock frequency never changes. The slow setting only moves the point at which read data is taken.

After reset, and again after the one configuration write the block accepts, it runs the SDRAM start-up sequence. The sequence is a precharge-all, then two back-to-back mode-register-set commands with identical address bits, then a programmable settle wait. Read and write requests are stalled while the sequence runs. The first accepted write locks the setting, so test software that strays into the configuration range later cannot disturb it.

The data bus is double data rate and delivers two bytes per cycle. The block captures the four cycles of an 8-byte burst at the configured latency and hands the bytes out one at a time with an index. The configuration port, the request port and the byte output all use valid/ready. A producer holds valid and its data until ready is seen high at a clock edge. The byte output holds data and index stable for as long as the consumer keeps ready low. The SDRAM side cannot be paused, so back-pressure on the byte output is absorbed by the burst buffer, and no new request is granted until the buffer has drained.

Top module: `sdram_timing_seq`

## Requirements
- R1: After reset the setting reads 0x02, `busy` is high, and a precharge-all is on `cmd` in the first cycle.
- R2: The start-up sequence is one precharge-all cycle (`cmd`=1, address bit 10 set), then two consecutive mode-register-set cycles (`cmd`=2) with the same address. That address carries the CAS latency in bits 6:4 and the burst-length code 3 in bits 2:0. Then come TMRD no-operation cycles (`cmd`=0) with `busy` still high, and after those `busy` falls.
- R3: While `busy` is high, `req_ready` and `cfg_wr_ready` are both low. `req_ready` is also low while `cfg_wr_valid` is high.
- R4: The first configuration handshake after reset loads bits 5:0 of the written byte in the following cycle and restarts the start-up sequence from the precharge.
- R5: Every later configuration handshake is ignored: the setting is unchanged and no start-up sequence runs.
- R6: Outside a write drive, `clk_phase` equals setting bits 1:0. `cap_fall` equals bit 2 and `extra_lat` equals bit 3.
- R7: An accepted write request raises `wr_drive` for WR_CYC cycles, starting the cycle after acceptance. While `wr_drive` is high and setting bit 4 is set, `clk_phase` is bits 1:0 with its upper bit inverted, which is a half-period shift.
- R8: Read bytes come from `dq_fall` when setting bit 2 is 1 and from `dq_rise` when it is 0.
- R9: For a read accepted at edge T, the bus words sampled at edges T+L through T+L+3 form the burst, with L = BASE_LAT plus setting bit 3. In each word the low byte comes before the high byte.
- R10: Burst bytes leave in order with `rd_idx` 0 to 7. Data and index hold while `rd_ready` is low. `req_ready` stays low until the byte with index 7 has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Host configuration write valid |
| cfg_wr_data | input | 8 | Host configuration byte (bits 7:6 unused) |
| cfg_wr_ready | output | 1 | Configuration write can be taken |
| cfg_value | output | 6 | Current timing setting |
| clk_phase | output | 2 | SDRAM clock phase select, including the write-time flip |
| cap_fall | output | 1 | Capture read data on the falling edge |
| extra_lat | output | 1 | One extra read latency cycle in force |
| busy | output | 1 | Start-up sequence in progress |
| cmd | output | 2 | SDRAM command: 0 no-op, 1 precharge-all, 2 mode-register-set |
| cmd_addr | output | ADDR_W | Address bits driven with the command |
| req_valid | input | 1 | Access request valid |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_ready | output | 1 | Request can be taken |
| wr_drive | output | 1 | Write data is being driven |
| dq_rise | input | 16 | Bus word captured on the rising edge |
| dq_fall | input | 16 | Bus word captured on the falling edge |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| rd_idx | output | 3 | Byte position within the burst |

## Verification
The properties assume that producers keep to the valid/ready rule. The configuration and request producers hold valid until they see ready, and the consumer may lower `rd_ready` in any cycle. They also assume that the bus words carry a fresh value every cycle, because capture slots are told apart only by their data. The stimulus changes inputs only at the falling clock edge, makes a new bus word from a running count on every cycle, and toggles `rd_ready` in some bursts to exercise back-pressure. It issues its configuration writes while the block is idle, and one of them while the setting is already locked, so that the ignore rule is exercised at the ports.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int CFG_W = 6;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_MRS = 2'd2
  } sd_cmd_e;

  typedef enum logic [2:0] {
    IS_PRE   = 3'd0,
    IS_MRS_A = 3'd1,
    IS_MRS_B = 3'd2,
    IS_WAIT  = 3'd3,
    IS_DONE  = 3'd4
  } init_st_e;

  typedef enum logic [1:0] {
    DP_IDLE = 2'd0,
    DP_CAP  = 2'd1,
    DP_OUT  = 2'd2
  } rd_st_e;

  // Field order is the software-visible bit order of the setting.
  typedef struct packed {
    logic       spare;
    logic       wr_inv;
    logic       extra_lat;
    logic       cap_fall;
    logic [1:0] phase;
  } tcfg_t;

  localparam logic [CFG_W-1:0] CFG_RESET = 6'h02;
endpackage

// File: rtl/sts_cfg_reg.sv
module sts_cfg_reg
  import sts_pkg::*;
#(
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              wr_ready,
  output tcfg_t             cfg,
  output logic              start_init
);
  logic locked;
  logic hs;
  logic unused_hi;

  assign hs         = wr_valid & wr_ready;
  assign start_init = hs & ~locked;
  assign unused_hi  = ^wr_data[HOST_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= tcfg_t'(CFG_RESET);
      locked <= 1'b0;
    end else if (start_init) begin
      cfg    <= tcfg_t'(wr_data[CFG_W-1:0]);
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/sts_init_seq.sv
module sts_init_seq
  import sts_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int CAS_LAT     = 3,
  parameter int BURST_BYTES = 8,
  parameter int TMRD        = 2,
  parameter int AP_BIT      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output sd_cmd_e           cmd,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int CNT_W = (TMRD > 1) ? $clog2(TMRD) : 1;
  localparam logic [CNT_W-1:0]  WAIT_LOAD = CNT_W'(TMRD - 1);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'((CAS_LAT % 8) << 4) | ADDR_W'($clog2(BURST_BYTES));
  localparam logic [ADDR_W-1:0] PRE_WORD = ADDR_W'(1) << AP_BIT;

  init_st_e         st;
  logic [CNT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IS_PRE;
      wait_cnt <= '0;
    end else begin
      unique case (st)
        IS_PRE:   st <= IS_MRS_A;
        IS_MRS_A: st <= IS_MRS_B;
        IS_MRS_B: begin
          st       <= IS_WAIT;
          wait_cnt <= WAIT_LOAD;
        end
        IS_WAIT: begin
          if (wait_cnt == '0) st <= IS_DONE;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        IS_DONE:  if (start) st <= IS_PRE;
        default:  st <= IS_DONE;
      endcase
    end
  end

  assign busy = (st != IS_DONE);

  always_comb begin
    cmd      = CMD_NOP;
    cmd_addr = '0;
    unique case (st)
      IS_PRE: begin
        cmd      = CMD_PRE;
        cmd_addr = PRE_WORD;
      end
      IS_MRS_A, IS_MRS_B: begin
        cmd      = CMD_MRS;
        cmd_addr = MODE_WORD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sts_datapath.sv
module sts_datapath
  import sts_pkg::*;
#(
  parameter int BASE_LAT    = 2,
  parameter int BURST_BYTES = 8,
  parameter int WR_CYC      = 4,
  parameter int IDX_W       = $clog2(BURST_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_ready,
  input  logic             extra_lat,
  input  logic             cap_fall,
  input  logic [15:0]      dq_rise,
  input  logic [15:0]      dq_fall,
  input  logic             rd_ready,
  output logic             idle,
  output logic             wr_drive,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx
);
  localparam int PAIRS = BURST_BYTES / 2;
  localparam int CNT_W = $clog2(BASE_LAT + 1 + PAIRS + 1);
  localparam int WR_W  = $clog2(WR_CYC + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_BYTES - 1);
  localparam logic [WR_W-1:0]  WR_LOAD  = WR_W'(WR_CYC);

  rd_st_e               st;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     lat_q;
  logic [CNT_W-1:0]     rel;
  logic [IDX_W-1:0]     idx;
  logic [WR_W-1:0]      wr_cnt;
  logic [15:0]          cap_word;
  logic                 in_win;
  logic                 last_slot;
  logic                 accept;
  logic [PAIRS*16-1:0]  words_flat;
  logic [IDX_W-2:0]     pair;
  logic [15:0]          out_word;

  assign accept    = req_valid & req_ready;
  assign cap_word  = cap_fall ? dq_fall : dq_rise;
  assign rel       = cnt - lat_q;
  assign in_win    = (st == DP_CAP) && (cnt >= lat_q);
  assign last_slot = in_win && (rel == CNT_W'(PAIRS - 1));

  for (genvar g = 0; g < PAIRS; g++) begin : g_slot
    logic [15:0] w_q;
    always_ff @(posedge clk) begin
      if (in_win && rel == CNT_W'(g)) w_q <= cap_word;
    end
    assign words_flat[g*16 +: 16] = w_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= DP_IDLE;
      cnt    <= '0;
      lat_q  <= '0;
      idx    <= '0;
      wr_cnt <= '0;
    end else begin
      if (accept && req_write) wr_cnt <= WR_LOAD;
      else if (wr_cnt != '0)   wr_cnt <= wr_cnt - 1'b1;

      unique case (st)
        DP_IDLE: begin
          if (accept && !req_write) begin
            st    <= DP_CAP;
            cnt   <= CNT_W'(1);
            lat_q <= CNT_W'(BASE_LAT) + CNT_W'(extra_lat);
          end
        end
        DP_CAP: begin
          cnt <= cnt + 1'b1;
          if (last_slot) begin
            st  <= DP_OUT;
            idx <= '0;
          end
        end
        DP_OUT: begin
          if (rd_ready) begin
            if (idx == LAST_IDX) st <= DP_IDLE;
            else                 idx <= idx + 1'b1;
          end
        end
        default: st <= DP_IDLE;
      endcase
    end
  end

  assign pair     = idx[IDX_W-1:1];
  assign out_word = words_flat[pair*16 +: 16];
  assign rd_data  = idx[0] ? out_word[15:8] : out_word[7:0];
  assign rd_idx   = idx;
  assign rd_valid = (st == DP_OUT);
  assign wr_drive = (wr_cnt != '0);
  assign idle     = (st == DP_IDLE) && (wr_cnt == '0);
endmodule

// File: rtl/sdram_timing_seq.sv
module sdram_timing_seq
  import sts_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int CAS_LAT     = 3,
  parameter int TMRD        = 2,
  parameter int BASE_LAT    = 2,
  parameter int BURST_BYTES = 8,
  parameter int WR_CYC      = 4,
  parameter int HOST_W      = 8,
  parameter int IDX_W       = $clog2(BURST_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_valid,
  input  logic [HOST_W-1:0] cfg_wr_data,
  output logic              cfg_wr_ready,
  output logic [CFG_W-1:0]  cfg_value,
  output logic [1:0]        clk_phase,
  output logic              cap_fall,
  output logic              extra_lat,
  output logic              busy,
  output logic [1:0]        cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  output logic              wr_drive,
  input  logic [15:0]       dq_rise,
  input  logic [15:0]       dq_fall,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic [IDX_W-1:0]  rd_idx
);
  tcfg_t   cfg;
  logic    start_init;
  logic    dp_idle;
  sd_cmd_e cmd_e;

  assign cfg_wr_ready = ~busy & dp_idle;
  assign req_ready    = ~busy & dp_idle & ~cfg_wr_valid;

  sts_cfg_reg #(.HOST_W(HOST_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (cfg_wr_valid),
    .wr_data    (cfg_wr_data),
    .wr_ready   (cfg_wr_ready),
    .cfg        (cfg),
    .start_init (start_init)
  );

  sts_init_seq #(
    .ADDR_W      (ADDR_W),
    .CAS_LAT     (CAS_LAT),
    .BURST_BYTES (BURST_BYTES),
    .TMRD        (TMRD)
  ) u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_init),
    .busy     (busy),
    .cmd      (cmd_e),
    .cmd_addr (cmd_addr)
  );

  sts_datapath #(
    .BASE_LAT    (BASE_LAT),
    .BURST_BYTES (BURST_BYTES),
    .WR_CYC      (WR_CYC),
    .IDX_W       (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .extra_lat (cfg.extra_lat),
    .cap_fall  (cfg.cap_fall),
    .dq_rise   (dq_rise),
    .dq_fall   (dq_fall),
    .rd_ready  (rd_ready),
    .idle      (dp_idle),
    .wr_drive  (wr_drive),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx)
  );

  assign cmd       = cmd_e;
  assign cfg_value = cfg;
  assign cap_fall  = cfg.cap_fall;
  assign extra_lat = cfg.extra_lat;
  assign clk_phase = cfg.phase ^ {cfg.wr_inv & wr_drive, 1'b0};
endmodule

// File: rtl/sdram_timing_seq_chk.sv
module sdram_timing_seq_chk
  import sts_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_valid,
  input logic              cfg_wr_ready,
  input logic [CFG_W-1:0]  cfg_value,
  input logic [1:0]        clk_phase,
  input logic              busy,
  input logic [1:0]        cmd,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              req_ready,
  input logic              wr_drive,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [7:0]        rd_data,
  input logic [IDX_W-1:0]  rd_idx
);
  logic seen_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)                            seen_wr <= 1'b0;
    else if (cfg_wr_valid && cfg_wr_ready) seen_wr <= 1'b1;
  end

  // R2: a mode-register-set opening is followed by a second identical one
  p_mrs_twice_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS && $past(cmd) != CMD_MRS) |=> (cmd == CMD_MRS && $stable(cmd_addr)));

  // R2: the mode-register-set pair is preceded by the precharge-all
  p_pre_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS && $past(cmd) != CMD_MRS) |-> $past(cmd) == CMD_PRE);

  // R3: no grant while the start-up sequence runs
  p_busy_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!req_ready && !cfg_wr_ready));

  // R4: the setting moves only right after a configuration handshake
  p_cfg_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_value) |-> $past(cfg_wr_valid && cfg_wr_ready));

  // R4: the first handshake restarts the sequence
  p_first_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_valid && cfg_wr_ready && !seen_wr) |=> (cmd == CMD_PRE && busy));

  // R5: once locked the setting never moves
  p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seen_wr) |-> $stable(cfg_value));

  // R6: no phase flip outside a write drive
  p_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_drive |-> clk_phase == cfg_value[1:0]);

  // R10: held byte stays put under back-pressure
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_idx)));
endmodule

bind sdram_timing_seq sdram_timing_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_sdram_timing_seq.sv
module tb_sdram_timing_seq;
  localparam int TMRD     = 2;
  localparam int BASE     = 2;
  localparam int CAS      = 3;
  localparam int AW       = 13;
  localparam int INIT_LEN = 3 + TMRD;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_valid;
  logic [7:0]    cfg_wr_data;
  logic          cfg_wr_ready;
  logic [5:0]    cfg_value;
  logic [1:0]    clk_phase;
  logic          cap_fall;
  logic          extra_lat;
  logic          busy;
  logic [1:0]    cmd;
  logic [AW-1:0] cmd_addr;
  logic          req_valid;
  logic          req_write;
  logic          req_ready;
  logic          wr_drive;
  logic [15:0]   dq_rise;
  logic [15:0]   dq_fall;
  logic          rd_valid;
  logic          rd_ready;
  logic [7:0]    rd_data;
  logic [2:0]    rd_idx;

  always #4 clk = ~clk;

  sdram_timing_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_data(cfg_wr_data),
    .cfg_wr_ready(cfg_wr_ready), .cfg_value(cfg_value), .clk_phase(clk_phase),
    .cap_fall(cap_fall), .extra_lat(extra_lat), .busy(busy), .cmd(cmd),
    .cmd_addr(cmd_addr), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .wr_drive(wr_drive), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_idx(rd_idx)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int ecnt   = 0;
  bit bp     = 1'b0;
  bit done   = 1'b0;

  // reference model state
  int         init_t;
  int         m_cfg;
  bit         m_locked;
  int         wr_left;
  bit         m_cap;
  bit         m_out;
  int         rd_t;
  int         m_lat;
  logic [7:0] q[$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
    ecnt++;
    dq_rise  = {8'(ecnt * 3 + 1), 8'(ecnt * 3)};
    dq_fall  = dq_rise ^ 16'hA5C3;
    rd_ready = bp ? ecnt[0] : 1'b1;
  endtask

  // model update at the edge, comparison 3 ns later
  always @(posedge clk) begin
    bit m_busy, m_idle, cfg_rdy, req_rdy, cfg_acc, req_acc;
    int exp_cmd, exp_addr, exp_phase;
    cyc++;
    if (cyc == 60000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
      summary();
    end
    if (!rst_n) begin
      init_t = 0; m_cfg = 2; m_locked = 0; wr_left = 0;
      m_cap = 0; m_out = 0; rd_t = 0; m_lat = 0; q.delete();
    end else begin
      m_busy  = init_t < INIT_LEN;
      m_idle  = !m_cap && !m_out && wr_left == 0;
      cfg_rdy = !m_busy && m_idle;
      req_rdy = cfg_rdy && !cfg_wr_valid;
      cfg_acc = cfg_wr_valid && cfg_rdy;
      req_acc = req_valid && req_rdy;
      if (cfg_acc && !m_locked) begin
        init_t = 0; m_cfg = cfg_wr_data & 8'h3F; m_locked = 1;
      end else if (init_t < INIT_LEN) init_t++;
      if (req_acc && req_write) wr_left = 4;
      else if (wr_left > 0) wr_left--;
      if (m_out) begin
        if (rd_ready) begin
          void'(q.pop_front());
          if (q.size() == 0) m_out = 0;
        end
      end else if (m_cap) begin
        if (rd_t >= m_lat) begin
          logic [15:0] w;
          w = m_cfg[2] ? dq_fall : dq_rise;
          q.push_back(w[7:0]);
          q.push_back(w[15:8]);
          if (rd_t - m_lat == 3) begin m_cap = 0; m_out = 1; end
        end
        rd_t++;
      end
      if (req_acc && !req_write) begin
        m_cap = 1; rd_t = 1; m_lat = BASE + m_cfg[3];
      end
    end
    #3;
    if (rst_n && !done) begin
      m_busy   = init_t < INIT_LEN;
      m_idle   = !m_cap && !m_out && wr_left == 0;
      exp_cmd  = (init_t == 0) ? 1 : (init_t <= 2) ? 2 : 0;
      exp_addr = (init_t == 0) ? 'h400 : (init_t <= 2) ? ((CAS << 4) | 3) : 0;
      exp_phase = (m_cfg & 3) ^ ((m_cfg[4] && wr_left > 0) ? 2 : 0);
      chk(cmd == 2'(exp_cmd), "R2 cmd", cmd, exp_cmd);
      chk(cmd_addr == AW'(exp_addr), "R2 cmd_addr", cmd_addr, exp_addr);
      chk(busy == m_busy, "R2 busy", busy, m_busy);
      chk(cfg_wr_ready == (!m_busy && m_idle), "R3 cfg_wr_ready", cfg_wr_ready, !m_busy && m_idle);
      chk(req_ready == (!m_busy && m_idle && !cfg_wr_valid), "R3 req_ready", req_ready,
          !m_busy && m_idle && !cfg_wr_valid);
      chk(cfg_value == 6'(m_cfg), m_locked ? "R5 cfg_value" : "R4 cfg_value", cfg_value, m_cfg);
      chk(clk_phase == 2'(exp_phase), wr_left > 0 ? "R7 clk_phase" : "R6 clk_phase", clk_phase, exp_phase);
      chk(cap_fall == m_cfg[2], "R6 cap_fall", cap_fall, m_cfg[2]);
      chk(extra_lat == m_cfg[3], "R6 extra_lat", extra_lat, m_cfg[3]);
      chk(wr_drive == (wr_left > 0), "R7 wr_drive", wr_drive, wr_left > 0);
      chk(rd_valid == m_out, "R9 rd_valid", rd_valid, m_out);
      if (m_out) begin
        chk(rd_data == q[0], m_cfg[2] ? "R8 rd_data" : "R9 rd_data", rd_data, q[0]);
        chk(rd_idx == 3'(8 - q.size()), "R10 rd_idx", rd_idx, 8 - q.size());
      end
    end
  end

  task automatic cfg_write(input logic [7:0] v);
    cfg_wr_valid = 1'b1;
    cfg_wr_data  = v;
    for (int k = 0; k < 200 && !cfg_wr_ready; k++) step();
    step();
    cfg_wr_valid = 1'b0;
  endtask

  task automatic request(input bit wr);
    req_valid = 1'b1;
    req_write = wr;
    for (int k = 0; k < 200 && !req_ready; k++) step();
    step();
    req_valid = 1'b0;
    for (int k = 0; k < 30; k++) step();
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_valid = 1'b0; cfg_wr_data = '0;
    req_valid = 1'b0; req_write = 1'b0; rd_ready = 1'b1;
    dq_rise = '0; dq_fall = '0;
    for (int k = 0; k < 3; k++) step();
    rst_n = 1'b1;
    #1;
    // R1: reset state visible before the first edge
    chk(cmd == 2'd1, "R1 cmd", cmd, 1);
    chk(busy == 1'b1, "R1 busy", busy, 1);
    chk(cfg_value == 6'h02, "R1 cfg_value", cfg_value, 2);
    for (int k = 0; k < 10; k++) step();
    request(1'b0);             // R9 default latency, rising edge
    bp = 1'b1;
    request(1'b0);             // R10 back-pressure
    bp = 1'b0;
    request(1'b1);             // R7 write, no inversion
    cfg_write(8'h9D);          // R4 phase 1, fall, extra, wr_inv
    for (int k = 0; k < 10; k++) step();
    chk(cfg_value == 6'h1D, "R4 loaded", cfg_value, 6'h1D);
    request(1'b0);             // R8 and R9 with the extra cycle
    request(1'b1);             // R7 inverted phase
    cfg_write(8'h00);          // R5 ignored
    chk(cfg_value == 6'h1D && !busy, "R5 ignored", {busy, cfg_value}, 6'h1D);
    bp = 1'b1;
    request(1'b0);
    summary();
  end
endmodule